// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits beside the processor bus of an 8-bit microcomputer with a 16-bit address space and decides, for every read and every write, which physical store answers. The possible targets are the main 48 KB RAM or its alternate copy, the I/O switch page, the small ROM of each peripheral slot, a 2 KB expansion window shared by all slots, the banked upper RAM (two switchable 4 KB banks plus an 8 KB region, repeated per block), the internal 4 KB slot-area ROM, and one of several 12 KB system ROM pages. For each qualified bus cycle it presents a region code and the byte offset inside that region, one clock after the cycle.

Reads and writes are decoded by two separate instances of the same decode path. Only the read path sees the shadow flags and the fall-back to system ROM. The block also holds the one piece of state the memory map needs: which slot currently owns the shared expansion window. An unshadowed touch of a slot ROM page claims the window for that slot. A touch of the last byte of the window gives it up. The memory arrays and the switch logic that produces the mode flags are outside the block. A read that reaches nothing returns a fixed filler byte, and a write that reaches nothing raises no write strobe.

Top module: `bank_map_decoder`

## Requirements
- R1: Addresses 0x0000-0xBFFF select main RAM (code 1) with offset equal to the address. A read selects the alternate copy (code 2) when `alt_rd_en` is set, and a write selects it when `alt_wr_en` is set. Each flag affects only its own direction.
- R2: Addresses 0xC000-0xC0FF select the I/O page (code 3) with offset address[7:0], for reads and writes alike, whatever the mode flags.
- R3: In 0xC100-0xC7FF, when not shadowed, the slot is address[10:8]. If that slot's bit in `slot_rom_mask` is set, the region is slot ROM (code 4) with offset {slot, address[7:0]}; otherwise the region is unmapped (code 0).
- R4: With `shadow_all` set, every read in 0xC100-0xCFFF selects the internal ROM (code 6) with offset address[11:0]. Writes in that range decode as if the flag were clear.
- R5: With `shadow_slot3` set, reads in 0xC300-0xC3FF select the internal ROM (code 6, offset address[11:0]). Other slots and all writes are unaffected.
- R6: A read or write in 0xC100-0xC7FF that is not shadowed makes address[10:8] the owner of the expansion window on the same clock edge. Shadowed reads leave the owner unchanged.
- R7: An access to 0xCFFF is decoded with the current owner and then clears the owner to 0. A read of 0xCFFF while `shadow_all` is set leaves the owner unchanged.
- R8: In 0xC800-0xCFFF, when not shadowed, the region is expansion ROM (code 5) with offset {owner, address[10:0]} if the owner is non-zero and its bit in `slot_exp_mask` is set; otherwise the region is unmapped (code 0).
- R9: In 0xD000-0xFFFF with `upper_rd_en` set, a read of 0xD000-0xDFFF selects D bank 1 (code 7) or, with `upper_alt_bank` set, D bank 2 (code 8), with offset {block, address[11:0]}. A read of 0xE000-0xFFFF selects the upper region (code 9) with offset {block, address[12:0]}.
- R10: In 0xD000-0xFFFF with `upper_rd_en` clear, a read selects system ROM (code 10) with offset rom_page*0x3000 + (address-0xD000).
- R11: Writes in 0xD000-0xFFFF follow the R9 decode when `upper_wr_en` is set and are unmapped (code 0) when it is clear. `upper_rd_en` has no effect on writes.
- R12: A read that resolves to code 0 drives `void_byte` to 0xF4; otherwise `void_byte` is 0x00. `wr_strobe` is high only for a write whose region is not code 0.
- R13: Outputs are registered: the decode of a cycle with `bus_valid` high appears with `acc_valid` high after the next rising edge. A cycle with `bus_valid` low yields `acc_valid` low and leaves the owner unchanged. A synchronous reset clears `acc_valid`, `wr_strobe`, `void_byte`, region, offset and owner to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Qualified bus cycle this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| alt_rd_en | input | 1 | Reads of 0x0000-0xBFFF use alternate RAM |
| alt_wr_en | input | 1 | Writes of 0x0000-0xBFFF use alternate RAM |
| shadow_all | input | 1 | Internal ROM shadows reads of 0xC100-0xCFFF |
| shadow_slot3 | input | 1 | Internal ROM shadows reads of 0xC300-0xC3FF |
| upper_rd_en | input | 1 | Upper RAM answers reads of 0xD000-0xFFFF |
| upper_wr_en | input | 1 | Upper RAM accepts writes of 0xD000-0xFFFF |
| upper_alt_bank | input | 1 | Selects the second 4 KB D bank |
| upper_block | input | BLK_W | Upper RAM block number |
| rom_page | input | PAGE_W | System ROM page |
| slot_rom_mask | input | 8 | Bit n set: slot n has a slot ROM |
| slot_exp_mask | input | 8 | Bit n set: slot n has an expansion ROM |
| acc_valid | output | 1 | Registered decode is valid |
| acc_write | output | 1 | Registered direction of the decoded cycle |
| acc_region | output | 4 | Region code (0 unmapped ... 10 system ROM) |
| acc_offset | output | OFF_W | Byte offset inside the region |
| wr_strobe | output | 1 | Write reaches a populated region |
| void_byte | output | 8 | 0xF4 for an unmapped read, else 0x00 |
| owner_slot | output | 3 | Current expansion-window owner |

## Verification
The embedded properties watch, on every cycle, the behaviours that depend only on the bus cycle just before: the I/O page decode, main RAM direction selection, write decodes ignoring the shadow flags, ownership being claimed and released, the filler byte on unmapped reads, the write strobe never firing for an unmapped target, and idle cycles leaving ownership alone. Offsets, bank and page arithmetic, the interplay of the two masks with the owner, and longer orderings (claim, shadowed touch, release, re-claim) are covered by the bench's vector sequence, whose expected values depend on the history it builds up, together with the directed reset and idle tests.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic [3:0] {
    RG_NONE     = 4'd0,
    RG_MAIN     = 4'd1,
    RG_MAIN_ALT = 4'd2,
    RG_IO       = 4'd3,
    RG_SLOT     = 4'd4,
    RG_EXP      = 4'd5,
    RG_INT      = 4'd6,
    RG_UPD      = 4'd7,
    RG_UPD_ALT  = 4'd8,
    RG_UPEF     = 4'd9,
    RG_SYSROM   = 4'd10
  } region_e;

  localparam logic [15:0] MAIN_LAST = 16'hBFFF;
  localparam logic [15:0] IO_LAST   = 16'hC0FF;
  localparam logic [15:0] SLOT_LAST = 16'hC7FF;
  localparam logic [15:0] EXP_LAST  = 16'hCFFF;
  localparam logic [15:0] D_LAST    = 16'hDFFF;
  localparam logic [15:0] ROM_BASE  = 16'hD000;
  localparam int          ROM_PAGE_BYTES = 'h3000;
  localparam logic [7:0]  FILLER_BYTE = 8'hF4;

  function automatic int off_width(input int blk_w, input int page_w);
    int w;
    w = 16;
    if (blk_w + 13 > w) w = blk_w + 13;
    if (page_w + 14 > w) w = page_w + 14;
    return w;
  endfunction

endpackage

// File: rtl/bmd_path.sv
module bmd_path
  import bmd_pkg::*;
#(
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 16
) (
  input  logic [15:0]       addr_i,
  input  logic              alt_i,
  input  logic              shadow_all_i,
  input  logic              shadow_s3_i,
  input  logic              up_en_i,
  input  logic              up_alt_i,
  input  logic              rom_fallback_i,
  input  logic [BLK_W-1:0]  block_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [7:0]        slot_mask_i,
  input  logic [7:0]        exp_mask_i,
  input  logic [2:0]        owner_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              claim_o,
  output logic              release_o
);

  logic [2:0] slot;
  logic       shadow_hit;

  assign slot       = addr_i[10:8];
  assign shadow_hit = shadow_all_i || (shadow_s3_i && (slot == 3'd3));

  always_comb begin
    region_o  = RG_NONE;
    off_o     = '0;
    claim_o   = 1'b0;
    release_o = 1'b0;
    if (addr_i <= MAIN_LAST) begin
      region_o = alt_i ? RG_MAIN_ALT : RG_MAIN;
      off_o    = OFF_W'(addr_i);
    end else if (addr_i <= IO_LAST) begin
      region_o = RG_IO;
      off_o    = OFF_W'(addr_i[7:0]);
    end else if (addr_i <= SLOT_LAST) begin
      if (shadow_hit) begin
        region_o = RG_INT;
        off_o    = OFF_W'(addr_i[11:0]);
      end else begin
        claim_o = 1'b1;
        if (slot_mask_i[slot]) begin
          region_o = RG_SLOT;
          off_o    = OFF_W'({slot, addr_i[7:0]});
        end
      end
    end else if (addr_i <= EXP_LAST) begin
      if (shadow_all_i) begin
        region_o = RG_INT;
        off_o    = OFF_W'(addr_i[11:0]);
      end else begin
        release_o = (addr_i == EXP_LAST);
        if ((owner_i != 3'd0) && exp_mask_i[owner_i]) begin
          region_o = RG_EXP;
          off_o    = OFF_W'({owner_i, addr_i[10:0]});
        end
      end
    end else if (up_en_i) begin
      if (addr_i <= D_LAST) begin
        region_o = up_alt_i ? RG_UPD_ALT : RG_UPD;
        off_o    = OFF_W'({block_i, addr_i[11:0]});
      end else begin
        region_o = RG_UPEF;
        off_o    = OFF_W'({block_i, addr_i[12:0]});
      end
    end else if (rom_fallback_i) begin
      region_o = RG_SYSROM;
      off_o    = OFF_W'(page_i) * OFF_W'(ROM_PAGE_BYTES) + OFF_W'(addr_i - ROM_BASE);
    end
  end

endmodule

// File: rtl/bmd_owner.sv
module bmd_owner (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_i,
  input  logic       claim_i,
  input  logic       release_i,
  input  logic [2:0] slot_i,
  output logic [2:0] owner_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_o <= 3'd0;
    end else if (upd_i) begin
      if (claim_i)        owner_o <= slot_i;
      else if (release_i) owner_o <= 3'd0;
    end
  end

endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmd_pkg::*;
#(
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 2,
  parameter int OFF_W  = bmd_pkg::off_width(BLK_W, PAGE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic              alt_rd_en,
  input  logic              alt_wr_en,
  input  logic              shadow_all,
  input  logic              shadow_slot3,
  input  logic              upper_rd_en,
  input  logic              upper_wr_en,
  input  logic              upper_alt_bank,
  input  logic [BLK_W-1:0]  upper_block,
  input  logic [PAGE_W-1:0] rom_page,
  input  logic [7:0]        slot_rom_mask,
  input  logic [7:0]        slot_exp_mask,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [3:0]        acc_region,
  output logic [OFF_W-1:0]  acc_offset,
  output logic              wr_strobe,
  output logic [7:0]        void_byte,
  output logic [2:0]        owner_slot
);

  region_e          rd_region, wr_region, sel_region;
  logic [OFF_W-1:0] rd_off, wr_off, sel_off;
  logic             rd_claim, wr_claim, rd_rel, wr_rel;

  bmd_path #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) i_rd_path (
    .addr_i         (bus_addr),
    .alt_i          (alt_rd_en),
    .shadow_all_i   (shadow_all),
    .shadow_s3_i    (shadow_slot3),
    .up_en_i        (upper_rd_en),
    .up_alt_i       (upper_alt_bank),
    .rom_fallback_i (1'b1),
    .block_i        (upper_block),
    .page_i         (rom_page),
    .slot_mask_i    (slot_rom_mask),
    .exp_mask_i     (slot_exp_mask),
    .owner_i        (owner_slot),
    .region_o       (rd_region),
    .off_o          (rd_off),
    .claim_o        (rd_claim),
    .release_o      (rd_rel)
  );

  bmd_path #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) i_wr_path (
    .addr_i         (bus_addr),
    .alt_i          (alt_wr_en),
    .shadow_all_i   (1'b0),
    .shadow_s3_i    (1'b0),
    .up_en_i        (upper_wr_en),
    .up_alt_i       (upper_alt_bank),
    .rom_fallback_i (1'b0),
    .block_i        (upper_block),
    .page_i         (rom_page),
    .slot_mask_i    (slot_rom_mask),
    .exp_mask_i     (slot_exp_mask),
    .owner_i        (owner_slot),
    .region_o       (wr_region),
    .off_o          (wr_off),
    .claim_o        (wr_claim),
    .release_o      (wr_rel)
  );

  assign sel_region = bus_we ? wr_region : rd_region;
  assign sel_off    = bus_we ? wr_off    : rd_off;

  bmd_owner i_owner (
    .clk       (clk),
    .rst       (rst),
    .upd_i     (bus_valid),
    .claim_i   (bus_we ? wr_claim : rd_claim),
    .release_i (bus_we ? wr_rel   : rd_rel),
    .slot_i    (bus_addr[10:8]),
    .owner_o   (owner_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid  <= 1'b0;
      acc_write  <= 1'b0;
      acc_region <= 4'd0;
      acc_offset <= '0;
      wr_strobe  <= 1'b0;
      void_byte  <= 8'h00;
    end else begin
      acc_valid <= bus_valid;
      if (bus_valid) begin
        acc_write  <= bus_we;
        acc_region <= sel_region;
        acc_offset <= sel_off;
        wr_strobe  <= bus_we && (sel_region != RG_NONE);
        void_byte  <= (!bus_we && (sel_region == RG_NONE)) ? FILLER_BYTE : 8'h00;
      end else begin
        wr_strobe  <= 1'b0;
        void_byte  <= 8'h00;
      end
    end
  end

  // R1
  main_rd_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_addr <= 16'hBFFF) |=>
      (acc_region == ($past(alt_rd_en) ? 4'd2 : 4'd1)));

  // R2
  io_page_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[15:8] == 8'hC0) |=> (acc_region == 4'd3 && acc_valid));

  // R4
  wr_no_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_addr >= 16'hC100 && bus_addr <= 16'hC7FF &&
     slot_rom_mask[bus_addr[10:8]]) |=> (acc_region == 4'd4));

  // R6
  owner_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr >= 16'hC100 && bus_addr <= 16'hC7FF &&
     (bus_we || !(shadow_all || (shadow_slot3 && bus_addr[10:8] == 3'd3)))) |=>
      (owner_slot == $past(bus_addr[10:8])));

  // R7
  owner_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr == 16'hCFFF && (bus_we || !shadow_all)) |=> (owner_slot == 3'd0));

  // R12
  filler_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_region == 4'd0) |-> (void_byte == 8'hF4));

  // R12
  strobe_target_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> (acc_valid && acc_write && acc_region != 4'd0));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!acc_valid && $stable(owner_slot)));

endmodule

// File: tb/test_bank_map_decoder.sv
module test_bank_map_decoder;

  localparam int OFF_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [11:0] mode = 12'h0;
  logic        acc_valid, acc_write, wr_strobe;
  logic [3:0]  acc_region;
  logic [OFF_W-1:0] acc_offset;
  logic [7:0]  void_byte;
  logic [2:0]  owner_slot;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  // mode bits: [11] alt rd, [10] alt wr, [9] shadow all, [8] shadow slot3,
  // [7] upper rd, [6] upper wr, [5] alt D bank, [4:2] block, [1:0] ROM page
  bank_map_decoder i_bank_map_decoder (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .alt_rd_en(mode[11]), .alt_wr_en(mode[10]), .shadow_all(mode[9]), .shadow_slot3(mode[8]),
    .upper_rd_en(mode[7]), .upper_wr_en(mode[6]), .upper_alt_bank(mode[5]),
    .upper_block(mode[4:2]), .rom_page(mode[1:0]),
    .slot_rom_mask(8'b1011_1110), .slot_exp_mask(8'b0010_0100),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_region(acc_region),
    .acc_offset(acc_offset), .wr_strobe(wr_strobe), .void_byte(void_byte),
    .owner_slot(owner_slot)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [11:0] md;
    logic [3:0]  rg;
    logic [15:0] off;
    logic [2:0]  own;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 12'h000, 4'd1,  16'h1234, 3'd0, 4'd1},  // R1 main read
    '{1'b0, 16'h1234, 12'h800, 4'd2,  16'h1234, 3'd0, 4'd1},  // R1 alt read
    '{1'b1, 16'h1234, 12'h800, 4'd1,  16'h1234, 3'd0, 4'd1},  // R1 write ignores alt read flag
    '{1'b1, 16'hBFFF, 12'h400, 4'd2,  16'hBFFF, 3'd0, 4'd1},  // R1 alt write
    '{1'b0, 16'hC030, 12'h000, 4'd3,  16'h0030, 3'd0, 4'd2},  // R2
    '{1'b1, 16'hC0FF, 12'h3C0, 4'd3,  16'h00FF, 3'd0, 4'd2},  // R2 flags irrelevant
    '{1'b0, 16'hC800, 12'h000, 4'd0,  16'h0000, 3'd0, 4'd8},  // R8 no owner
    '{1'b0, 16'hC2A5, 12'h000, 4'd4,  16'h02A5, 3'd2, 4'd3},  // R3 slot 2, R6 claim
    '{1'b0, 16'hC812, 12'h000, 4'd5,  16'h1012, 3'd2, 4'd8},  // R8 owner 2
    '{1'b0, 16'hC655, 12'h000, 4'd0,  16'h0000, 3'd6, 4'd3},  // R3 empty slot 6
    '{1'b0, 16'hC900, 12'h000, 4'd0,  16'h0000, 3'd6, 4'd8},  // R8 owner lacks exp ROM
    '{1'b1, 16'hC510, 12'h200, 4'd4,  16'h0510, 3'd5, 4'd4},  // R4 write ignores shadow
    '{1'b0, 16'hCABC, 12'h200, 4'd6,  16'h0ABC, 3'd5, 4'd4},  // R4 shadowed window
    '{1'b0, 16'hC123, 12'h200, 4'd6,  16'h0123, 3'd5, 4'd6},  // R6 shadowed read no claim
    '{1'b0, 16'hCFFF, 12'h200, 4'd6,  16'h0FFF, 3'd5, 4'd7},  // R7 shadowed no release
    '{1'b0, 16'hC340, 12'h100, 4'd6,  16'h0340, 3'd5, 4'd5},  // R5 slot3 shadow
    '{1'b0, 16'hC340, 12'h000, 4'd4,  16'h0340, 3'd3, 4'd5},  // R5 off
    '{1'b0, 16'hC440, 12'h100, 4'd4,  16'h0440, 3'd4, 4'd5},  // R5 other slot
    '{1'b0, 16'hC701, 12'h000, 4'd4,  16'h0701, 3'd7, 4'd3},  // R3 slot 7
    '{1'b0, 16'hC200, 12'h000, 4'd4,  16'h0200, 3'd2, 4'd6},  // R6 reclaim
    '{1'b0, 16'hCFFF, 12'h000, 4'd5,  16'h17FF, 3'd0, 4'd7},  // R7 decode then release
    '{1'b0, 16'hCFFF, 12'h000, 4'd0,  16'h0000, 3'd0, 4'd7},  // R7 released
    '{1'b0, 16'hC500, 12'h000, 4'd4,  16'h0500, 3'd5, 4'd6},  // R6
    '{1'b1, 16'hCFFF, 12'h200, 4'd5,  16'h2FFF, 3'd0, 4'd7},  // R7 write release
    '{1'b0, 16'hD123, 12'h000, 4'd10, 16'h0123, 3'd0, 4'd10}, // R10 page 0
    '{1'b0, 16'hFFFF, 12'h003, 4'd10, 16'hBFFF, 3'd0, 4'd10}, // R10 page 3
    '{1'b0, 16'hE000, 12'h002, 4'd10, 16'h7000, 3'd0, 4'd10}, // R10 page 2
    '{1'b0, 16'hD456, 12'h080, 4'd7,  16'h0456, 3'd0, 4'd9},  // R9 D bank 1
    '{1'b0, 16'hD456, 12'h0B4, 4'd8,  16'h5456, 3'd0, 4'd9},  // R9 D bank 2 block 5
    '{1'b0, 16'hE789, 12'h094, 4'd9,  16'hA789, 3'd0, 4'd9},  // R9 upper block 5
    '{1'b0, 16'hFFFF, 12'h09C, 4'd9,  16'hFFFF, 3'd0, 4'd9},  // R9 top byte block 7
    '{1'b1, 16'hD010, 12'h080, 4'd0,  16'h0000, 3'd0, 4'd11}, // R11 write disabled
    '{1'b1, 16'hD010, 12'h044, 4'd7,  16'h1010, 3'd0, 4'd11}, // R11 write D bank
    '{1'b1, 16'hF000, 12'h064, 4'd9,  16'h3000, 3'd0, 4'd11}, // R11 write upper
    '{1'b0, 16'hD010, 12'h041, 4'd10, 16'h3010, 3'd0, 4'd11}, // R11 write flag not for reads
    '{1'b1, 16'hE000, 12'h060, 4'd9,  16'h0000, 3'd0, 4'd11}  // R11
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic we, input logic [15:0] a, input logic [11:0] m);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; mode = m;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check(!acc_valid && !wr_strobe && void_byte == 8'h00 && owner_slot == 3'd0 &&
          acc_region == 4'd0 && acc_offset == '0, "R13", "reset state",
          {acc_valid, wr_strobe, void_byte, owner_slot, acc_region}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] exp_void;
      logic       exp_strobe;
      run_cycle(VECS[i].we, VECS[i].addr, VECS[i].md);
      exp_void   = (!VECS[i].we && VECS[i].rg == 4'd0) ? 8'hF4 : 8'h00;   // R12
      exp_strobe = VECS[i].we && (VECS[i].rg != 4'd0);                    // R12
      check(acc_valid && acc_write == VECS[i].we && acc_region == VECS[i].rg &&
            acc_offset == VECS[i].off && owner_slot == VECS[i].own &&
            void_byte == exp_void && wr_strobe == exp_strobe,
            $sformatf("R%0d/R12/R13 vec%0d", VECS[i].rq, i), "v,rg,off,own,void,stb",
            {acc_valid, acc_region, acc_offset, owner_slot, void_byte[3:0], wr_strobe},
            {1'b1, VECS[i].rg, VECS[i].off, VECS[i].own, exp_void[3:0], exp_strobe});
    end

    // R13 idle cycle keeps owner, no valid output
    run_cycle(1'b0, 16'hC400, 12'h000);
    check(owner_slot == 3'd4, "R6", "claim before idle", owner_slot, 3'd4);
    bus_valid = 1'b0; bus_addr = 16'hC2FF; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!acc_valid && owner_slot == 3'd4 && !wr_strobe, "R13", "idle cycle",
          {acc_valid, wr_strobe, owner_slot}, {2'b00, 3'd4});

    // R12 unmapped write: no strobe, no filler
    run_cycle(1'b1, 16'hC600, 12'h000);
    check(!wr_strobe && void_byte == 8'h00 && acc_region == 4'd0, "R12", "unmapped write",
          {wr_strobe, void_byte, acc_region}, 32'h0);

    // R13 synchronous reset mid-run clears owner
    check(owner_slot == 3'd6, "R6", "write claim slot 6", owner_slot, 3'd6);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(owner_slot == 3'd0 && !acc_valid && acc_region == 4'd0, "R13", "mid-run reset",
          {owner_slot, acc_valid, acc_region}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule